// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block produces the system reset for a chip. It watches a digital supply-good flag that an external comparator provides, a watchdog kick line from software, and the sampled levels that outside devices drive onto the two reset pins. From these it drives a reset pair of opposite polarity: `rst_hi_out` (active high) and `rst_lo_out` (active low). Reset is raised while the supply is bad, and for a hold period after power returns. It is also raised when an outside device pulls a reset pin to its active level, and when the watchdog expires.

All timing is counted in clock cycles through parameters, so simulation can use short values. `HOLD_CYC` sets the reset hold period, `GLITCH_CYC` the shortest supply dip that counts, and `WDT_CYC` the watchdog period. A dip in the supply flag is filtered out unless it lasts long enough. The watchdog is cleared by any level change on the kick line. It stays cleared and frozen for as long as reset is driven.

A sequencer in the top has three states. `ST_SUPPLY_LOW` is the state while the filtered supply is bad. `ST_HOLD` counts the hold period. `ST_RUN` means reset is released. The transitions are:
- power-good: `ST_SUPPLY_LOW` to `ST_HOLD`.
- hold-done: `ST_HOLD` to `ST_RUN`.
- hold-restart: `ST_HOLD` to `ST_HOLD`, with the counter cleared, while an external request is present.
- trigger: `ST_RUN` to `ST_HOLD`, on an external request or a watchdog timeout.
- brown-out: from any state to `ST_SUPPLY_LOW`.

The supply flag, the kick line and both pin inputs each pass through a two-flop synchroniser. `arst_n` only sets the flops to their starting values; its starting state is `ST_SUPPLY_LOW`.

Top module: `supply_reset_ctrl`

## Requirements
- R1: While the supply-good flag is low, `rst_hi_out` is 1 and `rst_lo_out` is 0.
- R2: After the supply-good flag rises, reset remains asserted for at least `HOLD_CYC` and at most `HOLD_CYC`+8 clock cycles, then releases.
- R3: A supply-good dip of fewer than `GLITCH_CYC` consecutive sampled low cycles does not touch the reset outputs. A dip of `GLITCH_CYC`+2 cycles asserts reset within `GLITCH_CYC`+6 cycles of its start.
- R4: With reset released and no kick transition for `WDT_CYC` cycles, reset asserts no earlier than `WDT_CYC`-4 and no later than `WDT_CYC`+8 cycles after the last transition. It is then held for a full hold period.
- R5: A rising edge and a falling edge of `wdt_kick` each clear the watchdog. Level toggles spaced less than `WDT_CYC`-8 cycles apart keep reset released indefinitely.
- R6: While reset is asserted the watchdog neither counts nor times out. After any release, a full `WDT_CYC` window passes before a timeout, however long reset was held.
- R7: A 1 on `rst_hi_pin` or a 0 on `rst_lo_pin` asserts reset within 5 cycles. While the request stays present it keeps restarting the hold. Reset releases between `HOLD_CYC` and `HOLD_CYC`+8 cycles after the request is removed.
- R8: `rst_lo_out` is the complement of `rst_hi_out` in every cycle.
- R9: While `arst_n` is 0, reset is asserted (`rst_hi_out`=1, `rst_lo_out`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous flop initialisation, active low |
| supply_ok | input | 1 | Supply-good flag from the external comparator, 1 = good |
| wdt_kick | input | 1 | Watchdog kick; any level change clears the watchdog |
| rst_hi_pin | input | 1 | Level driven by outside devices on the active-high reset pin; 1 requests reset |
| rst_lo_pin | input | 1 | Level driven by outside devices on the active-low reset pin; 0 requests reset |
| rst_hi_out | output | 1 | Reset, active high |
| rst_lo_out | output | 1 | Reset, active low |

## Verification
Supply dips of random length below the filter width are interleaved with a dip just above it. This separates the glitch filter from the brown-out path. Kick sequences toggle the level at random spacing, so consecutive edges alternate in direction; an edge detector that saw only one direction would let the watchdog expire. A long active-low pin request that outlasts both the hold period and the watchdog period shows whether the watchdog was frozen during reset and whether the hold restarts until the request ends. A silent period after kicking stops checks when the watchdog fires and that a full hold follows.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_HOLD       = 2'd1,
        ST_RUN        = 2'd2
    } sup_state_t;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stg[gi] <= RST_VAL;
                    else         stg[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stg[gi] <= RST_VAL;
                    else         stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/srs_glitch_filter.sv
module srs_glitch_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ok_s,
    output logic bad_o
);

    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
    localparam logic [CW-1:0] LIM = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt <= LIM;
            bad_o   <= 1'b1;
        end else if (ok_s) begin
            low_cnt <= '0;
            bad_o   <= 1'b0;
        end else begin
            if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
            if (low_cnt == LIM) bad_o <= 1'b1;
        end
    end

    // R3: a single good sample ends the bad indication
    assert_good_sample_clears_R3: assert property (@(posedge clk) disable iff (!arst_n)
        ok_s |=> !bad_o);
    // R3: a brown-out indication only follows a low sample
    assert_rise_needs_low_R3: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(bad_o) |-> !$past(ok_s));

endmodule

// File: rtl/srs_watchdog.sv
module srs_watchdog #(
    parameter int WDT_CYC = 300
) (
    input  logic clk,
    input  logic arst_n,
    input  logic kick_s,
    input  logic rst_active,
    output logic timeout_o
);

    localparam int CW = $clog2(WDT_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(WDT_CYC - 1);

    logic          kick_d;
    logic          kick_edge;
    logic [CW-1:0] cnt;

    assign kick_edge = kick_s ^ kick_d;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) kick_d <= 1'b0;
        else         kick_d <= kick_s;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt       <= '0;
            timeout_o <= 1'b0;
        end else if (rst_active || kick_edge) begin
            cnt       <= '0;
            timeout_o <= 1'b0;
        end else begin
            if (cnt != LIMIT) cnt <= cnt + 1'b1;
            timeout_o <= (cnt == LIMIT);
        end
    end

    // R6: frozen and cleared while reset is driven
    assert_frozen_in_reset_R6: assert property (@(posedge clk) disable iff (!arst_n)
        rst_active |=> (cnt == '0) && !timeout_o);
    // R5: either direction of kick edge clears the count
    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!arst_n)
        kick_edge |=> (cnt == '0) && !timeout_o);

endmodule

// File: rtl/srs_seq_fsm.sv
module srs_seq_fsm
    import supply_reset_pkg::*;
#(
    parameter int HOLD_CYC = 64
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_bad,
    input  logic ext_req,
    input  logic wdt_to,
    output logic rst_hi_o,
    output logic rst_lo_o
);

    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    sup_state_t    state, state_n;
    logic [HW-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (supply_bad) begin
            state_n = ST_SUPPLY_LOW;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_SUPPLY_LOW: begin
                    state_n = ST_HOLD;
                    cnt_n   = '0;
                end
                ST_HOLD: begin
                    if (ext_req) begin
                        cnt_n = '0;
                    end else if (cnt == HOLD_LAST) begin
                        state_n = ST_RUN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (ext_req || wdt_to) begin
                        state_n = ST_HOLD;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = ST_SUPPLY_LOW;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_SUPPLY_LOW;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_hi_o <= 1'b1;
            rst_lo_o <= 1'b0;
        end else begin
            rst_hi_o <= (state_n != ST_RUN);
            rst_lo_o <= (state_n == ST_RUN);
        end
    end

    assert_supply_low_holds_R1: assert property (@(posedge clk) disable iff (!arst_n)
        supply_bad |=> rst_hi_o && !rst_lo_o);
    assert_release_after_hold_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_hi_o) |-> $past(state) == ST_HOLD);
    assert_timeout_starts_hold_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (wdt_to && state == ST_RUN && !supply_bad) |=> rst_hi_o && state == ST_HOLD);
    assert_ext_req_holds_R7: assert property (@(posedge clk) disable iff (!arst_n)
        ext_req |=> rst_hi_o);
    assert_opposite_polarity_R8: assert property (@(posedge clk) disable iff (!arst_n)
        rst_hi_o != rst_lo_o);

endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl #(
    parameter int HOLD_CYC    = 64,
    parameter int GLITCH_CYC  = 4,
    parameter int WDT_CYC     = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic wdt_kick,
    input  logic rst_hi_pin,
    input  logic rst_lo_pin,
    output logic rst_hi_out,
    output logic rst_lo_out
);

    // bit order: 3 supply, 2 kick, 1 hi pin, 0 lo pin
    localparam int NIN = 4;
    localparam logic [NIN-1:0] IDLE_VAL = 4'b0001;

    logic [NIN-1:0] raw, synced;
    logic           supply_bad;
    logic           ext_req;
    logic           wdt_to;

    assign raw = {supply_ok, wdt_kick, rst_hi_pin, rst_lo_pin};

    srs_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (raw),
        .q      (synced)
    );

    srs_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk    (clk),
        .arst_n (arst_n),
        .ok_s   (synced[3]),
        .bad_o  (supply_bad)
    );

    assign ext_req = synced[1] | ~synced[0];

    srs_watchdog #(.WDT_CYC(WDT_CYC)) u_wdt (
        .clk        (clk),
        .arst_n     (arst_n),
        .kick_s     (synced[2]),
        .rst_active (rst_hi_out),
        .timeout_o  (wdt_to)
    );

    srs_seq_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .supply_bad (supply_bad),
        .ext_req    (ext_req),
        .wdt_to     (wdt_to),
        .rst_hi_o   (rst_hi_out),
        .rst_lo_o   (rst_lo_out)
    );

endmodule

// File: tb/supply_reset_ctrl_test.sv
`timescale 1ns/1ps
module supply_reset_ctrl_test;

    localparam int HOLD   = 64;
    localparam int GLITCH = 4;
    localparam int WDT    = 300;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic wdt_kick = 1'b0;
    logic rst_hi_pin = 1'b0;
    logic rst_lo_pin = 1'b1;
    logic rst_hi_out, rst_lo_out;

    int n_total = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    supply_reset_ctrl #(.HOLD_CYC(HOLD), .GLITCH_CYC(GLITCH), .WDT_CYC(WDT)) uut (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .wdt_kick(wdt_kick),
        .rst_hi_pin(rst_hi_pin), .rst_lo_pin(rst_lo_pin),
        .rst_hi_out(rst_hi_out), .rst_lo_out(rst_lo_out)
    );

    function automatic int hold_min(); return HOLD; endfunction
    function automatic int hold_max(); return HOLD + 8; endfunction
    function automatic int wdt_min();  return WDT - 4; endfunction
    function automatic int wdt_max();  return WDT + 8; endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    // R8: polarity checked every cycle
    always @(negedge clk) begin
        if (arst_n && !done) check(rst_lo_out === ~rst_hi_out, "R8", int'(rst_lo_out), int'(~rst_hi_out));
    end

    // count cycles while reset is asserted
    task automatic time_reset(output int n);
        n = 0;
        while (rst_hi_out && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // count cycles until reset asserts (limit)
    task automatic time_quiet(input int limit, output int n);
        n = 0;
        while (!rst_hi_out && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int gap;
        int seen;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(rst_hi_out === 1'b1 && rst_lo_out === 1'b0, "R9", int'(rst_hi_out), 1);
        arst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(rst_hi_out === 1'b1, "R1", int'(rst_hi_out), 1);

        // R2: power-up hold
        supply_ok = 1'b1;
        time_reset(n);
        check(n >= hold_min() && n <= hold_max(), "R2", n, HOLD);

        // R3: short random dips ignored
        for (int i = 0; i < 6; i++) begin
            int len = $urandom_range(GLITCH - 1, 1);
            seen = 0;
            supply_ok = 1'b0;
            repeat (len) begin @(negedge clk); seen |= int'(rst_hi_out); end
            supply_ok = 1'b1;
            repeat (8) begin @(negedge clk); seen |= int'(rst_hi_out); end
            check(seen == 0, "R3", seen, 0);
        end

        // R3: dip just above the filter width
        supply_ok = 1'b0;
        n = 0;
        repeat (GLITCH + 2) begin @(negedge clk); if (!rst_hi_out) n++; end
        supply_ok = 1'b1;
        while (!rst_hi_out && n < 50) begin @(negedge clk); n++; end
        check(n <= GLITCH + 6, "R3", n, GLITCH + 6);
        time_reset(n);
        check(n >= hold_min() && n <= hold_max() + 4, "R2", n, HOLD);

        // R5: toggled kicks, alternating edge direction
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            gap = $urandom_range(WDT * 3 / 4, WDT / 4);
            repeat (gap) begin @(negedge clk); seen |= int'(rst_hi_out); end
            wdt_kick = ~wdt_kick;
        end
        // directed: near-limit spacing
        repeat (WDT - 12) begin @(negedge clk); seen |= int'(rst_hi_out); end
        wdt_kick = ~wdt_kick;
        check(seen == 0, "R5", seen, 0);

        // R4: silence after the last kick
        time_quiet(WDT + 20, n);
        check(n >= wdt_min() && n <= wdt_max(), "R4", n, WDT);
        time_reset(n);
        check(n >= hold_min() && n <= hold_max(), "R4", n, HOLD);

        // R7: short pulse on active-high pin
        repeat (10) @(negedge clk);
        rst_hi_pin = 1'b1;
        repeat (3) @(negedge clk);
        rst_hi_pin = 1'b0;
        n = 0;
        while (!rst_hi_out && n < 20) begin @(negedge clk); n++; end
        check(rst_hi_out === 1'b1, "R7", int'(rst_hi_out), 1);
        time_reset(n);
        check(n >= hold_min() && n <= hold_max(), "R7", n, HOLD);

        // R7/R6: long request on active-low pin, longer than hold and watchdog
        repeat (10) @(negedge clk);
        rst_lo_pin = 1'b0;
        repeat (5) @(negedge clk);
        seen = 0;
        repeat (2 * WDT) begin @(negedge clk); if (!rst_hi_out) seen++; end
        check(seen == 0, "R7", seen, 0);
        rst_lo_pin = 1'b1;
        time_reset(n);
        check(n >= hold_min() && n <= hold_max(), "R7", n, HOLD);
        // R6: full watchdog window after release despite long reset
        time_quiet(WDT + 20, n);
        check(n >= WDT - 2 && n <= wdt_max(), "R6", n, WDT);
        time_reset(n);
        check(n >= hold_min() && n <= hold_max(), "R4", n, HOLD);

        // R1: brown-out during run, held while low
        supply_ok = 1'b0;
        repeat (GLITCH + 40) @(negedge clk);
        check(rst_hi_out === 1'b1 && rst_lo_out === 1'b0, "R1", int'(rst_hi_out), 1);
        supply_ok = 1'b1;
        time_reset(n);
        check(n >= hold_min() && n <= hold_max(), "R2", n, HOLD);

        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

endmodule